// File: doc/BRIEF.md
# Interrupt Processor-Side Signalling Port

This block is the processor-facing half of an interrupt controller. A distributor presents one candidate, meaning the most urgent pending interrupt with its 10-bit ID and 8-bit priority. The block raises a request line to its processor only when that candidate is more urgent than two limits. The first is a programmable priority mask. The second is the priority of the interrupt the processor is already servicing. Lower numeric priority means more urgent.

Software uses a 32-bit register port to claim and retire interrupts. An acknowledge read returns the candidate's ID and marks it active. An end-of-interrupt write retires the most recently claimed ID. Active priorities are kept on a small stack, so a nested, pre-empting interrupt hands the running priority back to the one it interrupted when it retires.

The candidate input is a level snapshot with no back-pressure. The distributor may change it in any cycle, and the block samples it only in cycles where it decides something. The claim and done outputs are single-cycle pulses with no ready. The distributor must take each pulse in the cycle it appears, clearing pending state on a claim and active state on a done. Register reads return data combinationally in the cycle `bus_rd` is high. The side effects of a read or write take place at the following clock edge. `bus_rd` and `bus_wr` are never both high.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset the request line is low, and the control, mask and binary-point registers read 0. The running priority reads 0xFF, and an acknowledge read returns 0x3FF.
- R2: The register offsets are fixed.
  - Offsets: control 0x00 (bit 0 = enable), mask 0x04 (bits [7:0]), binary point 0x08 (bits [2:0]), acknowledge 0x0C, end-of-interrupt 0x10, running priority 0x14, highest pending 0x18.
  - Control, mask and binary point read back what was written, within their widths.
  - Writes to any other offset are ignored, and reads of unused offsets return 0.
- R3: An interrupt qualifies only when all of these hold: the block is enabled, the candidate is valid, the candidate's priority is strictly below both the mask and the running priority, and the stack has room. The request line follows qualification one clock later. Equal priority does not qualify.
- R4: An acknowledge read while the candidate qualifies does three things.
  - It returns the ID in bits [9:0] and the CPU_ID parameter in bits [11:10].
  - It pushes the candidate, so the running priority becomes the candidate's priority.
  - It pulses `claim_valid` with `claim_id` in the next cycle.
- R5: An acknowledge read with no qualifying candidate returns 0x3FF and changes no state.
- R6: The request line is low in the cycle after an acknowledge. After that it is re-evaluated against the new running priority.
- R7: An end-of-interrupt write whose bits [9:0] match the most recently acknowledged ID does three things.
  - It pops the stack.
  - It restores the previous running priority, or 0xFF when the stack empties.
  - It pulses `done_valid` with `done_id` in the next cycle.
- R8: An end-of-interrupt write with a non-matching ID, or with nothing active, is ignored.
- R9: A highest-pending read returns the candidate ID in bits [9:0] and CPU_ID in bits [11:10]. It returns 0x3FF when no candidate is valid. The read has no side effect.
- R10: With STACK_DEPTH interrupts active, nothing is signalled or claimed until one retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | Distributor has a pending candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, 0 most urgent |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq_req | output | 1 | Interrupt request to the processor |
| claim_valid | output | 1 | One-cycle pulse: an interrupt became active |
| claim_id | output | 10 | ID claimed |
| done_valid | output | 1 | One-cycle pulse: an interrupt retired |
| done_id | output | 10 | ID retired |

## Verification
The assertions watch the active stack and the acknowledge path on every cycle:
- the stack never overflows or underflows;
- each push is more urgent than the entry beneath it;
- an acknowledge always lowers the running priority number, and a retire always raises it;
- a spurious acknowledge leaves the stack depth unchanged;
- the request line is low after every claim.

Only the bench scenarios can show the rest. These cover the exact strict-inequality boundaries against mask and running priority, the returned ID and CPU field values, rejection of a mismatched retire, priority restoration through nested pre-emption, and the full-stack lockout that lifts after a retire.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;
  localparam int ID_W    = 10;
  localparam int PRIO_W  = 8;
  localparam int BPT_W   = 3;
  localparam int CPUID_W = 2;
  localparam int REG_W   = 32;
  localparam int OFS_W   = 5;

  localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'h3FF;
  localparam logic [PRIO_W-1:0] IDLE_PRIO   = 8'hFF;

  // software-visible offsets
  localparam logic [OFS_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_PMASK = 5'h04;
  localparam logic [OFS_W-1:0] OFS_BPT   = 5'h08;
  localparam logic [OFS_W-1:0] OFS_ACK   = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_EOI   = 5'h10;
  localparam logic [OFS_W-1:0] OFS_RUN   = 5'h14;
  localparam logic [OFS_W-1:0] OFS_HPEND = 5'h18;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } act_ent_t;
endpackage

// File: rtl/irq_act_stack.sv
module irq_act_stack
  import irq_cpu_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  act_ent_t                     push_ent,
  input  logic                         pop,
  output act_ent_t                     top_ent,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  act_ent_t         slot [DEPTH];
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (push) cnt <= cnt + 1'b1;
    else if (pop)  cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && cnt == CNT_W'(i)) slot[i] <= push_ent;
    end
  end

  // empty stack presents the idle priority, so running priority falls out
  always_comb begin
    top_ent = '{id: SPURIOUS_ID, prio: IDLE_PRIO};
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt == CNT_W'(i + 1)) top_ent = slot[i];
    end
  end

  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));
  assign level = cnt;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8
  AST_NEST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !empty) |-> (push_ent.prio < top_ent.prio)); // R4
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cand_valid,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [PRIO_W-1:0] pmask,
  input  logic [PRIO_W-1:0] run_prio,
  input  logic              room,
  input  logic              take,
  output logic              qual,
  output logic              irq
);
  // strict comparison on both limits: equal priority never pre-empts
  assign qual = en && cand_valid && room &&
                (cand_prio < pmask) && (cand_prio < run_prio);

  always_ff @(posedge clk) begin
    if (!rst_n)    irq <= 1'b0;
    else if (take) irq <= 1'b0;
    else           irq <= qual;
  end
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import irq_cpu_pkg::*;
#(
  parameter int                  STACK_DEPTH = 4,
  parameter logic [CPUID_W-1:0]  CPU_ID      = 2'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_req,
  output logic              claim_valid,
  output logic [ID_W-1:0]   claim_id,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id
);
  localparam int LVL_W = $clog2(STACK_DEPTH + 1);
  localparam int PAD_W = REG_W - ID_W - CPUID_W;

  logic              en_q;
  logic [PRIO_W-1:0] pmask_q;
  logic [BPT_W-1:0]  bpt_q;

  act_ent_t          top_ent;
  logic              stk_empty, stk_full;
  logic [LVL_W-1:0]  stk_level;
  logic              qual;
  logic [PRIO_W-1:0] run_prio;

  logic ack_rd, ack_fire, spur_rd, eoi_fire;

  assign run_prio = top_ent.prio;
  assign ack_rd   = bus_rd && (bus_addr == OFS_ACK);
  assign ack_fire = ack_rd && qual;
  assign spur_rd  = ack_rd && !qual;
  assign eoi_fire = bus_wr && (bus_addr == OFS_EOI) && !stk_empty &&
                    (bus_wdata[ID_W-1:0] == top_ent.id);

  irq_act_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack_fire),
    .push_ent ('{id: cand_id, prio: cand_prio}),
    .pop      (eoi_fire),
    .top_ent  (top_ent),
    .empty    (stk_empty),
    .full     (stk_full),
    .level    (stk_level)
  );

  irq_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_q),
    .cand_valid (cand_valid),
    .cand_prio  (cand_prio),
    .pmask      (pmask_q),
    .run_prio   (run_prio),
    .room       (!stk_full),
    .take       (ack_fire),
    .qual       (qual),
    .irq        (irq_req)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pmask_q <= '0;
      bpt_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_CTRL:  en_q    <= bus_wdata[0];
        OFS_PMASK: pmask_q <= bus_wdata[PRIO_W-1:0];
        OFS_BPT:   bpt_q   <= bus_wdata[BPT_W-1:0];
        default:   ;
      endcase
    end
  end

  // claim / retire notifications to the distributor
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claim_valid <= 1'b0;
      claim_id    <= '0;
      done_valid  <= 1'b0;
      done_id     <= '0;
    end else begin
      claim_valid <= ack_fire;
      done_valid  <= eoi_fire;
      if (ack_fire) claim_id <= cand_id;
      if (eoi_fire) done_id  <= top_ent.id;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL:  bus_rdata = REG_W'(en_q);
        OFS_PMASK: bus_rdata = REG_W'(pmask_q);
        OFS_BPT:   bus_rdata = REG_W'(bpt_q);
        OFS_ACK:   bus_rdata = qual ? {{PAD_W{1'b0}}, CPU_ID, cand_id}
                                    : REG_W'(SPURIOUS_ID);
        OFS_RUN:   bus_rdata = REG_W'(run_prio);
        OFS_HPEND: bus_rdata = cand_valid ? {{PAD_W{1'b0}}, CPU_ID, cand_id}
                                          : REG_W'(SPURIOUS_ID);
        default:   bus_rdata = '0;
      endcase
    end
  end

  AST_ACK_RAISES_URGENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (run_prio < $past(run_prio))); // R4
  AST_EOI_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |=> (run_prio > $past(run_prio))); // R7
  AST_SPURIOUS_KEEPS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    spur_rd |=> $stable(stk_level)); // R5
  AST_QUIET_AFTER_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !irq_req); // R6
endmodule

// File: tb/irq_cpu_port_tb.sv
`timescale 1ns/1ps
module irq_cpu_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req, claim_valid, done_valid;
  logic [9:0]  claim_id, done_id;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] last_rd;
  logic        last_irq, last_claim, last_done;
  logic [9:0]  last_claim_id, last_done_id;

  always #4 clk = ~clk;

  irq_cpu_port #(.STACK_DEPTH(4), .CPU_ID(2'd1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .claim_valid(claim_valid), .claim_id(claim_id),
    .done_valid(done_valid), .done_id(done_id)
  );

  localparam logic [1:0] NOP = 2'd0, WR = 2'd1, RD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  a;
    logic [31:0] d;     // write data, or expected read data
    logic        cv;
    logic [9:0]  cid;
    logic [7:0]  cp;
    logic        xirq;  // expected request line two edges later
    logic [3:0]  req;
  } vec_t;

  localparam int VN = 36;
  localparam vec_t TBL [VN] = '{
    '{RD, 5'h00, 32'h0,   1'b0, 10'h000, 8'h00, 1'b0, 4'd1},  // R1
    '{RD, 5'h04, 32'h0,   1'b0, 10'h000, 8'h00, 1'b0, 4'd1},  // R1
    '{RD, 5'h14, 32'hFF,  1'b0, 10'h000, 8'h00, 1'b0, 4'd1},  // R1
    '{RD, 5'h0C, 32'h3FF, 1'b0, 10'h000, 8'h00, 1'b0, 4'd5},  // R5
    '{WR, 5'h04, 32'hF0,  1'b1, 10'h028, 8'h80, 1'b0, 4'd2},  // R2 disabled
    '{RD, 5'h04, 32'hF0,  1'b1, 10'h028, 8'h80, 1'b0, 4'd2},  // R2
    '{WR, 5'h00, 32'h1,   1'b1, 10'h028, 8'h80, 1'b1, 4'd3},  // R3
    '{RD, 5'h00, 32'h1,   1'b1, 10'h028, 8'h80, 1'b1, 4'd2},  // R2
    '{RD, 5'h18, 32'h428, 1'b1, 10'h028, 8'h80, 1'b1, 4'd9},  // R9
    '{RD, 5'h18, 32'h428, 1'b1, 10'h028, 8'h80, 1'b1, 4'd9},  // R9 no side effect
    '{RD, 5'h0C, 32'h428, 1'b1, 10'h028, 8'h80, 1'b0, 4'd4},  // R4
    '{RD, 5'h14, 32'h80,  1'b1, 10'h028, 8'h80, 1'b0, 4'd4},  // R4
    '{NOP,5'h00, 32'h0,   1'b1, 10'h029, 8'h80, 1'b0, 4'd3},  // R3 equal running
    '{NOP,5'h00, 32'h0,   1'b1, 10'h029, 8'h40, 1'b1, 4'd6},  // R6 pre-empts
    '{RD, 5'h0C, 32'h429, 1'b1, 10'h029, 8'h40, 1'b0, 4'd4},  // R4
    '{WR, 5'h10, 32'h028, 1'b0, 10'h000, 8'h00, 1'b0, 4'd8},  // R8 mismatch
    '{RD, 5'h14, 32'h40,  1'b0, 10'h000, 8'h00, 1'b0, 4'd8},  // R8
    '{WR, 5'h10, 32'h029, 1'b0, 10'h000, 8'h00, 1'b0, 4'd7},  // R7
    '{RD, 5'h14, 32'h80,  1'b0, 10'h000, 8'h00, 1'b0, 4'd7},  // R7 restored
    '{WR, 5'h10, 32'h028, 1'b0, 10'h000, 8'h00, 1'b0, 4'd7},  // R7
    '{RD, 5'h14, 32'hFF,  1'b0, 10'h000, 8'h00, 1'b0, 4'd7},  // R7 idle
    '{WR, 5'h10, 32'h028, 1'b0, 10'h000, 8'h00, 1'b0, 4'd8},  // R8 empty
    '{RD, 5'h14, 32'hFF,  1'b0, 10'h000, 8'h00, 1'b0, 4'd8},  // R8
    '{WR, 5'h08, 32'hFF,  1'b0, 10'h000, 8'h00, 1'b0, 4'd2},  // R2
    '{RD, 5'h08, 32'h7,   1'b0, 10'h000, 8'h00, 1'b0, 4'd2},  // R2 width
    '{WR, 5'h14, 32'h0,   1'b0, 10'h000, 8'h00, 1'b0, 4'd2},  // R2 read-only
    '{RD, 5'h14, 32'hFF,  1'b0, 10'h000, 8'h00, 1'b0, 4'd2},  // R2
    '{NOP,5'h00, 32'h0,   1'b1, 10'h005, 8'hF0, 1'b0, 4'd3},  // R3 equal mask
    '{RD, 5'h0C, 32'h3FF, 1'b1, 10'h005, 8'hF8, 1'b0, 4'd5},  // R5 masked
    '{RD, 5'h18, 32'h3FF, 1'b0, 10'h000, 8'h00, 1'b0, 4'd9},  // R9 none
    '{RD, 5'h1C, 32'h0,   1'b0, 10'h000, 8'h00, 1'b0, 4'd2},  // R2 unused
    '{WR, 5'h00, 32'h0,   1'b1, 10'h005, 8'h10, 1'b0, 4'd3},  // R3 disable
    '{WR, 5'h00, 32'h1,   1'b1, 10'h005, 8'h10, 1'b1, 4'd3},  // R3
    '{RD, 5'h0C, 32'h405, 1'b1, 10'h005, 8'h10, 1'b0, 4'd4},  // R4
    '{WR, 5'h10, 32'h005, 1'b1, 10'h005, 8'h10, 1'b1, 4'd7},  // R7 re-qualifies
    '{NOP,5'h00, 32'h0,   1'b0, 10'h000, 8'h00, 1'b0, 4'd3}   // R3
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive at negedge; op takes effect at next edge; irq sampled after second edge
  task automatic step(input logic [1:0] op, input logic [4:0] a, input logic [31:0] d,
                      input logic cv, input logic [9:0] cid, input logic [7:0] cp);
    @(negedge clk);
    cand_valid = cv; cand_id = cid; cand_prio = cp;
    bus_addr = a; bus_wr = (op == WR); bus_rd = (op == RD); bus_wdata = d;
    #1 last_rd = bus_rdata;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    last_claim = claim_valid; last_claim_id = claim_id;
    last_done = done_valid;   last_done_id = done_id;
    @(negedge clk);
    last_irq = irq_req;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq_req == 1'b0, "R1", 32'(irq_req), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < VN; i++) begin
      step(TBL[i].op, TBL[i].a, TBL[i].d, TBL[i].cv, TBL[i].cid, TBL[i].cp);
      if (TBL[i].op == RD)
        check(last_rd == TBL[i].d, $sformatf("R%0d row %0d rdata", TBL[i].req, i),
              last_rd, TBL[i].d);
      check(last_irq == TBL[i].xirq, $sformatf("R%0d row %0d irq", TBL[i].req, i),
            32'(last_irq), 32'(TBL[i].xirq));
    end

    // R10: fill the stack with nested claims
    for (int k = 0; k < 4; k++) begin
      step(RD, 5'h0C, 32'h0, 1'b1, 10'(100 + k), 8'(8'h70 - 8'h10 * k));
      check(last_rd == 32'(32'h400 | (100 + k)), "R4 nested ack", last_rd,
            32'(32'h400 | (100 + k)));
      check(last_claim && last_claim_id == 10'(100 + k), "R4 claim pulse",
            {21'h0, last_claim, last_claim_id}, {21'h0, 1'b1, 10'(100 + k)});
    end
    step(NOP, 5'h00, 32'h0, 1'b1, 10'd200, 8'h08);
    check(last_irq == 1'b0, "R10 full no irq", 32'(last_irq), 32'h0);
    step(RD, 5'h0C, 32'h0, 1'b1, 10'd200, 8'h08);
    check(last_rd == 32'h3FF, "R10 full spurious", last_rd, 32'h3FF);
    check(last_claim == 1'b0, "R10 no claim", 32'(last_claim), 32'h0);
    step(RD, 5'h14, 32'h0, 1'b1, 10'd200, 8'h08);
    check(last_rd == 32'h40, "R10 running kept", last_rd, 32'h40);
    step(WR, 5'h10, 32'd103, 1'b1, 10'd200, 8'h08);
    check(last_done && last_done_id == 10'd103, "R7 done pulse",
          {21'h0, last_done, last_done_id}, {21'h0, 1'b1, 10'd103});
    check(last_irq == 1'b1, "R10 room again", 32'(last_irq), 32'h1);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(irq_req == 1'b0, "R1 reset irq", 32'(irq_req), 32'h0);
    rst_n = 1'b1;
    step(RD, 5'h14, 32'h0, 1'b0, 10'h0, 8'h0);
    check(last_rd == 32'hFF, "R1 reset running", last_rd, 32'hFF);
    step(RD, 5'h04, 32'h0, 1'b0, 10'h0, 8'h0);
    check(last_rd == 32'h0, "R1 reset mask", last_rd, 32'h0);
    step(RD, 5'h08, 32'h0, 1'b0, 10'h0, 8'h0);
    check(last_rd == 32'h0, "R1 reset bpt", last_rd, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule